// File: doc/BRIEF.md
# Dual-Channel Timer Compare Unit

This block watches the value of an external free-running counter and raises two independent compare events against it. Each of the two channels owns a compare register. When its channel is switched on and the counter value equals that register on a timer tick, the channel arms. The match is committed on the following timer tick: the channel's status flag goes high, its compare output pin inverts, and an interrupt line rises if that channel's interrupt is allowed. The counter itself is not part of the block. The block only receives the counter value and a strobe that marks each counter advance.

Software uses a small register bus that responds in the same cycle. Address 0 holds an 8-bit control/status byte. Addresses 1 and 2 hold the compare registers of channel 0 and channel 1. A status flag is cleared by writing 0 to it. If a commit lands in the same cycle as such a clear, the commit wins.

Each channel runs a two-state machine:
- IDLE waits for a match. IDLE→ARMED is taken on a tick where the channel is on and the counter equals the compare value.
- ARMED holds a registered match. ARMED→ARMED is taken on a tick that commits and matches again. ARMED→IDLE is taken on a tick that commits without a new match, or at any time the channel is switched off, which drops the pending match.

Top module: `dual_compare_unit`

## Requirements
- R1: After reset, the control/status byte reads 0x0C, both compare registers read 0, and both compare outputs and both interrupt lines are 0.
- R2: The compare registers of channel 0 and channel 1 are written and read back at bus addresses 1 and 2. The control/status byte at address 0 has these fields: bit 7 is the channel 1 flag, bit 6 the channel 0 flag, bit 5 and bit 4 are the interrupt enables of channels 1 and 0, bit 1 and bit 0 are the operation enables of channels 1 and 0. Upper read bits are 0.
- R3: If a channel is on and a tick cycle shows a counter value equal to its compare register, nothing is visible until the next tick cycle. The clock edge ending that later tick sets the flag and inverts the compare output.
- R4: A channel whose operation enable is 0 produces no flag and no output change. Clearing the enable while a match is pending cancels that match.
- R5: In cycles without the tick strobe, no comparison is made and no pending match is committed, whatever the counter value is.
- R6: Writing 0 to a flag bit clears it. Writing 1 to a flag bit leaves it unchanged.
- R7: When a commit and a software write of 0 to the same flag fall in one cycle, the flag ends as 1.
- R8: A channel's interrupt line is 1 exactly when its flag and its interrupt enable are both 1.
- R9: Bits 3 and 2 of the control/status byte always read 1, and writes to them have no effect.
- R10: Both channels can match and commit on the same ticks, each inverting its own output independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address: 0 control/status, 1 compare 0, 2 compare 1 |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data for bus_addr, returned in the same cycle |
| cnt_value | input | CW | Current free-running counter value |
| cnt_tick | input | 1 | High for one clock on each counter advance |
| cmp_out | output | 2 | Compare output pins, one per channel |
| irq | output | 2 | Level interrupt requests, one per channel |

## Verification
Two events can land in the same cycle, and the bench forces both.

In the first case, a commit and a software clear of the same flag coincide. The bench arms channel 0 and then presents the commit tick in the very cycle it writes 0 to that flag. After that edge it expects the flag to read 1 and the output to have inverted.

In the second case, both channels commit on one tick. The bench gives both channels the same compare value and expects both flags, both interrupt lines, and two opposite output inversions after that single tick.

// File: rtl/dcu_pkg.sv
package dcu_pkg;
    localparam int NCH = 2;
    localparam int AW  = 2;

    localparam logic [AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [AW-1:0] ADDR_CMP0 = 2'd1;

    // control/status byte field positions (channel index is added)
    localparam int EN_BASE   = 0;
    localparam int IE_BASE   = 4;
    localparam int FLAG_BASE = 6;

    typedef enum logic {
        CH_IDLE  = 1'b0,
        CH_ARMED = 1'b1
    } ch_state_t;
endpackage

// File: rtl/dcu_channel.sv
module dcu_channel
    import dcu_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic [CW-1:0] cnt_value,
    input  logic [CW-1:0] cmp_value,
    output logic          commit
);
    ch_state_t state_q, state_d;
    logic      hit;

    assign hit = (cnt_value == cmp_value);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (en && tick && hit) state_d = CH_ARMED;
            end
            CH_ARMED: begin
                if (!en)       state_d = CH_IDLE;
                else if (tick) state_d = hit ? CH_ARMED : CH_IDLE;
            end
        endcase
    end

    always_comb begin
        commit = 1'b0;
        unique case (state_q)
            CH_IDLE:  commit = 1'b0;
            CH_ARMED: commit = en && tick;
        endcase
    end
endmodule

// File: rtl/dcu_regs.sv
module dcu_regs
    import dcu_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           bus_addr,
    input  logic                    bus_we,
    input  logic [CW-1:0]           bus_wdata,
    output logic [CW-1:0]           bus_rdata,
    input  logic [NCH-1:0]          commit,
    output logic [NCH-1:0]          flag,
    output logic [NCH-1:0]          ie,
    output logic [NCH-1:0]          en,
    output logic [NCH-1:0][CW-1:0]  cmp,
    output logic [NCH-1:0]          pin
);
    logic       wr_ctrl;
    logic [7:0] ctrl_byte;

    assign wr_ctrl = bus_we && (bus_addr == ADDR_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie <= '0;
            en <= '0;
        end else if (wr_ctrl) begin
            ie <= bus_wdata[IE_BASE +: NCH];
            en <= bus_wdata[EN_BASE +: NCH];
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [AW-1:0] MY_ADDR = ADDR_CMP0 + AW'(i);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  flag[i] <= 1'b0;
            else if (commit[i])          flag[i] <= 1'b1;
            else if (wr_ctrl && !bus_wdata[FLAG_BASE + i]) flag[i] <= 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         pin[i] <= 1'b0;
            else if (commit[i]) pin[i] <= ~pin[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               cmp[i] <= '0;
            else if (bus_we && bus_addr == MY_ADDR)   cmp[i] <= bus_wdata;
        end
    end

    assign ctrl_byte = {flag[1], flag[0], ie[1], ie[0], 2'b11, en[1], en[0]};

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL) begin
            bus_rdata = {{(CW-8){1'b0}}, ctrl_byte};
        end else begin
            for (int k = 0; k < NCH; k++) begin
                if (bus_addr == ADDR_CMP0 + AW'(k)) bus_rdata = cmp[k];
            end
        end
    end
endmodule

// File: rtl/dual_compare_unit.sv
module dual_compare_unit
    import dcu_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_we,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    input  logic [CW-1:0] cnt_value,
    input  logic          cnt_tick,
    output logic [1:0]    cmp_out,
    output logic [1:0]    irq
);
    logic [NCH-1:0]         commit;
    logic [NCH-1:0]         flag;
    logic [NCH-1:0]         ie;
    logic [NCH-1:0]         en;
    logic [NCH-1:0][CW-1:0] cmp;

    dcu_regs #(.CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .commit    (commit),
        .flag      (flag),
        .ie        (ie),
        .en        (en),
        .cmp       (cmp),
        .pin       (cmp_out)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        dcu_channel #(.CW(CW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (en[i]),
            .tick      (cnt_tick),
            .cnt_value (cnt_value),
            .cmp_value (cmp[i]),
            .commit    (commit[i])
        );
    end

    assign irq = flag & ie;
endmodule

// File: rtl/dcu_checks.sv
module dcu_checks #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnt_tick,
    input logic [1:0]    bus_addr,
    input logic [CW-1:0] bus_rdata,
    input logic [1:0]    cmp_out,
    input logic [1:0]    irq,
    input logic [1:0]    commit,
    input logic [1:0]    flag,
    input logic [1:0]    ie,
    input logic [1:0]    en
);
    for (genvar i = 0; i < 2; i++) begin : g_chk
        // R3 / R7: a commit always leaves the flag set, even against a clear
        a_r7_commit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            commit[i] |=> flag[i]);
        // R3: a commit inverts the pin
        a_r3_commit_toggles: assert property (@(posedge clk) disable iff (!rst_n)
            commit[i] |=> (cmp_out[i] != $past(cmp_out[i])));
        // R3: the pin holds without a commit
        a_r3_hold_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
            !commit[i] |=> $stable(cmp_out[i]));
        // R5: commits happen only on ticks
        a_r5_commit_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
            commit[i] |-> cnt_tick);
        // R4: a switched-off channel never commits
        a_r4_off_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
            !en[i] |-> !commit[i]);
        // R8: the interrupt requires the enable
        a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> (ie[i] && flag[i]));
    end

    // R9: unused bits read as ones
    a_r9_reserved_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> (bus_rdata[3:2] == 2'b11));
endmodule

bind dual_compare_unit dcu_checks #(.CW(CW)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_tick  (cnt_tick),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .cmp_out   (cmp_out),
    .irq       (irq),
    .commit    (commit),
    .flag      (flag),
    .ie        (ie),
    .en        (en)
);

// File: tb/dual_compare_unit_test.sv
module dual_compare_unit_test;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [CW-1:0] bus_wdata = '0;
    logic [CW-1:0] bus_rdata;
    logic [CW-1:0] cnt_value = '0;
    logic          cnt_tick = 1'b0;
    logic [1:0]    cmp_out;
    logic [1:0]    irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          pins;   // 0: read data, 1: {irq, cmp_out}
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;   // 50 MHz

    dual_compare_unit #(.CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_value(cnt_value),
        .cnt_tick(cnt_tick), .cmp_out(cmp_out), .irq(irq)
    );

    // monitor: pops expected items at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = sb.pop_front();
                act = it.pins ? {12'h000, irq, cmp_out} : bus_rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        step();
        bus_we = 1'b0;
    endtask

    task automatic tick(input logic [15:0] v);
        cnt_value = v; cnt_tick = 1'b1;
        step();
        cnt_tick = 1'b0;
    endtask

    task automatic exp_reg(input logic [1:0] a, input logic [15:0] v, input string tag);
        bus_addr = a;
        sb.push_back('{pins: 1'b0, exp: v, tag: tag});
        @(negedge clk);
        #1;
    endtask

    task automatic exp_pins(input logic [3:0] v, input string tag);
        sb.push_back('{pins: 1'b1, exp: {12'h000, v}, tag: tag});
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        exp_reg(0, 16'h000C, "R1 ctrl reset");
        exp_reg(1, 16'h0000, "R1 cmp0 reset");
        exp_reg(2, 16'h0000, "R1 cmp1 reset");
        exp_pins(4'h0, "R1 pins reset");

        // R2 compare registers
        wr(1, 16'd5);
        wr(2, 16'd9);
        exp_reg(1, 16'd5, "R2 cmp0 readback");
        exp_reg(2, 16'd9, "R2 cmp1 readback");
        wr(0, 16'h0011);
        exp_reg(0, 16'h001D, "R2 ctrl layout en0 ie0");

        // R3 delayed commit, R5 no commit without tick
        tick(16'd4);
        tick(16'd5);
        exp_reg(0, 16'h001D, "R3 flag not yet set");
        exp_pins(4'h0, "R3 pin not yet toggled");
        step(); step();
        exp_pins(4'h0, "R5 pending waits for tick");
        tick(16'd6);
        exp_reg(0, 16'h005D, "R3 flag set on next tick");
        exp_pins(4'h5, "R3 pin toggled R8 irq0");

        // R6 clear by zero
        wr(0, 16'h0011);
        exp_reg(0, 16'h001D, "R6 flag cleared");
        exp_pins(4'h1, "R8 irq drops with flag");

        // R4 disabled channel 1 ignores a match
        tick(16'd9);
        tick(16'd10);
        exp_reg(0, 16'h001D, "R4 ch1 off no flag");
        exp_pins(4'h1, "R4 ch1 off no toggle");

        // R5 counter stopped on a matching value
        cnt_value = 16'd5;
        step(); step(); step();
        tick(16'd7);
        exp_reg(0, 16'h001D, "R5 stopped counter no match");
        exp_pins(4'h1, "R5 stopped counter pins");

        // R7 set beats clear
        tick(16'd5);
        cnt_value = 16'd6; cnt_tick = 1'b1;
        bus_addr = 0; bus_we = 1'b1; bus_wdata = 16'h0011;
        step();
        cnt_tick = 1'b0; bus_we = 1'b0;
        exp_reg(0, 16'h005D, "R7 set wins over clear");
        exp_pins(4'h4, "R7 pin toggled back");

        // R6 writing one is no effect, R9 reserved
        wr(0, 16'h0011);
        wr(0, 16'h00D1);
        exp_reg(0, 16'h001D, "R6 write one keeps flag clear");
        wr(0, 16'h0001);
        exp_reg(0, 16'h000D, "R9 reserved bits stay one");

        // R8 flag without enable gives no interrupt
        tick(16'd5);
        tick(16'd6);
        exp_reg(0, 16'h004D, "R8 flag set ie0 off");
        exp_pins(4'h1, "R8 no irq without enable");
        wr(0, 16'h0051);
        exp_pins(4'h5, "R8 irq after enable");

        // R10 both channels on one tick
        wr(2, 16'd5);
        wr(0, 16'h0033);
        exp_reg(0, 16'h003F, "R10 both enabled");
        tick(16'd5);
        tick(16'd6);
        exp_reg(0, 16'h00FF, "R10 both flags");
        exp_pins(4'hE, "R10 both toggled both irq");

        // R4 disabling while armed cancels
        tick(16'd5);
        wr(0, 16'h0030);
        tick(16'd6);
        exp_reg(0, 16'h003C, "R4 cancelled pending");
        exp_pins(4'h2, "R4 cancelled pins");

        step();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule